// File: doc/BRIEF.md
# Programmable Conversion Cycle Scheduler

This block decides when a measurement cycle (one conversion followed by a limit compare) begins. A free-running base tick arrives every 125 ms. The block divides that tick by a power of two chosen by a 3-bit rate code. Code 7 divides by 1, giving eight cycles per second. Each lower code halves the rate, so code 0 divides by 128 and gives one cycle every 16 s. On each boundary of the divided period, the block emits a single-clock start pulse. It then waits for a done pulse from the converter before it will launch another cycle.

The rate code sits in a small register inside the block. Only the three low bits of a write are kept, and the upper bits always read back as zero. A standby input stops periodic starts. While standby is asserted, a one-shot strobe launches exactly one cycle, and the block then returns to waiting in standby. The data that accompanies a one-shot write is irrelevant, so the block takes only the strobe. Writing a new rate code restarts the period count, and so does holding the block in standby.

Top module: `conv_sched`

## Requirements
- R1: After reset, start_o and busy_o are low and rate_rdata_o reads 0x02.
- R2: A rate write stores bits [2:0] of rate_wdata_i. The next cycle, rate_rdata_o returns those bits, and bits [7:3] read as zero whatever was written there (writing 0xFD reads back 0x05).
- R3: In run mode (standby_i = 0) with rate code c, start_o pulses once for every 2^(7-c) base ticks. Code 7 gives a pulse on every tick, code 5 on every 4th tick and code 0 on every 128th tick.
- R4: start_o is high for exactly one clock cycle. It is high in the cycle after the clock edge that sampled the tick completing the period.
- R5: A rate write restarts the period count. The next periodic start comes exactly one new period (in ticks) after the write.
- R6: While standby_i = 1, ticks cause no start, and the period count is held at zero. After a return to run mode, the first start comes one full period later.
- R7: In standby with no cycle in progress, a one-shot strobe gives exactly one start pulse. No further start follows until another strobe arrives.
- R8: A one-shot strobe in run mode, or while a cycle is in progress, produces no start.
- R9: busy_o rises together with start_o and falls in the cycle after done_i. A period boundary that falls while busy_o is high produces no start.
- R10: done_i while no cycle is in progress has no effect: busy_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Base 125 ms tick, one clock wide |
| standby_i | input | 1 | 1 = standby, 0 = run |
| oneshot_i | input | 1 | One-shot write strobe |
| rate_we_i | input | 1 | Rate register write enable |
| rate_wdata_i | input | 8 | Rate register write data |
| rate_rdata_o | output | 8 | Rate register readback, upper five bits zero |
| done_i | input | 1 | Converter reports cycle complete |
| start_o | output | 1 | One-cycle start of a conversion cycle |
| busy_o | output | 1 | A cycle is in progress |

## Verification
Periodic operation is exercised at the fastest code, a middle code and the slowest code. Together these separate a correct power-of-two mapping from one that is off by a factor of two or runs in the reversed direction. Tick counts stop one tick short of a boundary and then cross it, which exposes a divider that ends its count one tick early or late. A rate rewrite partway through a period, and a standby interval entered with a partly filled count, show whether the count really restarts rather than carrying over. Separate one-shot patterns (in standby, in run, while busy, and after a stray done) distinguish the exactly-one-cycle behaviour from strobes that should be dropped.

// File: rtl/conv_sched_pkg.sv
package conv_sched_pkg;
  // Number of base ticks in one period for a given rate code.
  // The largest code divides by one; each lower code doubles the period.
  function automatic int unsigned period_ticks(input int unsigned code,
                                               input int unsigned code_w);
    int unsigned max_code;
    max_code = (1 << code_w) - 1;
    return 1 << (max_code - code);
  endfunction
endpackage

// File: rtl/conv_rate_reg.sv
module conv_rate_reg #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CODE_W     = 3,
  parameter logic [7:0]  RESET_CODE = 8'h02
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CODE_W-1:0] wcode_i,
  output logic [CODE_W-1:0] code_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              restart_o
);
  localparam int unsigned PAD_W = DATA_W - CODE_W;

  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) code_q <= RESET_CODE[CODE_W-1:0];
    else if (we_i) code_q <= wcode_i;
  end

  assign code_o    = code_q;
  assign rdata_o   = {{PAD_W{1'b0}}, code_q};
  assign restart_o = we_i;

  // R2
  code_follows_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> code_o == $past(wcode_i));
endmodule

// File: rtl/conv_tick_div.sv
module conv_tick_div
  import conv_sched_pkg::*;
#(
  parameter int unsigned CODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              clr_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              wrap_o
);
  localparam int unsigned CNT_W = (1 << CODE_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_val;
  logic             at_last;

  assign last_val = CNT_W'(period_ticks(int'(code_i), CODE_W) - 1);
  assign at_last  = (cnt_q == last_val);
  assign wrap_o   = tick_i && at_last && !clr_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end

  // R3
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last_val);
  // R6
  clr_empties_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/conv_cycle_ctrl.sv
module conv_cycle_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wrap_i,
  input  logic standby_i,
  input  logic oneshot_i,
  input  logic done_i,
  output logic start_o,
  output logic busy_o
);
  logic run_fire;
  logic os_fire;
  logic fire;
  logic start_q;
  logic busy_q;

  assign run_fire = wrap_i && !standby_i && !busy_q;
  assign os_fire  = oneshot_i && standby_i && !busy_q;
  assign fire     = run_fire || os_fire;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      start_q <= fire;
      if (fire)        busy_q <= 1'b1;
      else if (done_i) busy_q <= 1'b0;
    end
  end

  assign start_o = start_q;
  assign busy_o  = busy_q;

  // R4
  start_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  // R9
  start_sets_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> busy_o);
  // R9
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_i |=> busy_o);
  // R9
  busy_blocks_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !start_o);
  // R8
  os_run_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !standby_i && !wrap_i |=> !start_o);
  // R6
  standby_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i && !oneshot_i |=> !start_o);
  // R10
  idle_done_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !wrap_i && !oneshot_i |=> !busy_o);
endmodule

// File: rtl/conv_sched.sv
module conv_sched #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CODE_W     = 3,
  parameter logic [7:0]  RESET_CODE = 8'h02
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              standby_i,
  input  logic              oneshot_i,
  input  logic              rate_we_i,
  input  logic [DATA_W-1:0] rate_wdata_i,
  output logic [DATA_W-1:0] rate_rdata_o,
  input  logic              done_i,
  output logic              start_o,
  output logic              busy_o
);
  logic [CODE_W-1:0] code;
  logic              restart;
  logic              div_clr;
  logic              wrap;

  conv_rate_reg #(
    .DATA_W(DATA_W), .CODE_W(CODE_W), .RESET_CODE(RESET_CODE)
  ) rate_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (rate_we_i),
    .wcode_i  (rate_wdata_i[CODE_W-1:0]),
    .code_o   (code),
    .rdata_o  (rate_rdata_o),
    .restart_o(restart)
  );

  assign div_clr = restart || standby_i;

  conv_tick_div #(.CODE_W(CODE_W)) div_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .clr_i (div_clr),
    .code_i(code),
    .wrap_o(wrap)
  );

  conv_cycle_ctrl ctrl_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wrap_i   (wrap),
    .standby_i(standby_i),
    .oneshot_i(oneshot_i),
    .done_i   (done_i),
    .start_o  (start_o),
    .busy_o   (busy_o)
  );

  // R2
  reserved_bits_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rate_we_i && (rate_wdata_i[DATA_W-1:CODE_W] != '0) |=>
      rate_rdata_o[DATA_W-1:CODE_W] == '0);
  // R2
  readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rate_we_i |=> rate_rdata_o[CODE_W-1:0] == $past(rate_wdata_i[CODE_W-1:0]));
endmodule

// File: tb/conv_sched_tb_top.sv
`timescale 1ns/1ps
module conv_sched_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       standby_i = 1'b0;
  logic       oneshot_i = 1'b0;
  logic       rate_we_i = 1'b0;
  logic [7:0] rate_wdata_i = 8'h00;
  logic [7:0] rate_rdata_o;
  logic       done_i;
  logic       start_o;
  logic       busy_o;

  logic mdl_done = 1'b0;
  logic man_done = 1'b0;
  int   conv_cnt = 0;
  int   lat = 2;
  int   nstarts = 0;
  int   n_checks = 0;
  int   n_fails = 0;
  bit   finished = 1'b0;

  always #2 clk = ~clk;

  assign done_i = mdl_done | man_done;

  conv_sched dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .standby_i(standby_i),
    .oneshot_i(oneshot_i), .rate_we_i(rate_we_i), .rate_wdata_i(rate_wdata_i),
    .rate_rdata_o(rate_rdata_o), .done_i(done_i), .start_o(start_o),
    .busy_o(busy_o)
  );

  // Converter stand-in: done pulse a fixed number of cycles after start.
  always @(negedge clk) begin
    mdl_done = 1'b0;
    if (!rst_ni) conv_cnt = 0;
    else if (conv_cnt > 0) begin
      conv_cnt = conv_cnt - 1;
      if (conv_cnt == 0) mdl_done = 1'b1;
    end else if (start_o) conv_cnt = lat;
  end

  always @(negedge clk) if (start_o) nstarts = nstarts + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tick(input int gap);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    idle(gap);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) pulse_tick(4);
  endtask

  task automatic write_rate(input logic [7:0] v);
    rate_we_i = 1'b1;
    rate_wdata_i = v;
    @(negedge clk);
    rate_we_i = 1'b0;
  endtask

  task automatic pulse_oneshot();
    oneshot_i = 1'b1;
    @(negedge clk);
    oneshot_i = 1'b0;
  endtask

  task automatic t_reset();
    check(start_o == 1'b0, "R1 start", int'(start_o), 0);
    check(busy_o == 1'b0, "R1 busy", int'(busy_o), 0);
    check(rate_rdata_o == 8'h02, "R1 rate", int'(rate_rdata_o), 2);
  endtask

  task automatic t_readback();
    write_rate(8'hFD);
    check(rate_rdata_o == 8'h05, "R2 reserved bits", int'(rate_rdata_o), 5);
    write_rate(8'h07);
    check(rate_rdata_o == 8'h07, "R2 code 7", int'(rate_rdata_o), 7);
  endtask

  task automatic t_pulse_shape();
    write_rate(8'h07);
    idle(2);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    check(start_o == 1'b1, "R4 start after tick", int'(start_o), 1);
    check(busy_o == 1'b1, "R9 busy with start", int'(busy_o), 1);
    @(negedge clk);
    check(start_o == 1'b0, "R4 one cycle wide", int'(start_o), 0);
    idle(6);
    check(busy_o == 1'b0, "R9 busy cleared by done", int'(busy_o), 0);
  endtask

  task automatic t_rates();
    write_rate(8'h07);
    nstarts = 0;
    ticks(5);
    check(nstarts == 5, "R3 code 7", nstarts, 5);
    write_rate(8'h05);
    nstarts = 0;
    ticks(3);
    check(nstarts == 0, "R3 code 5 before boundary", nstarts, 0);
    ticks(9);
    check(nstarts == 3, "R3 code 5", nstarts, 3);
    write_rate(8'h00);
    nstarts = 0;
    ticks(127);
    check(nstarts == 0, "R3 code 0 before boundary", nstarts, 0);
    ticks(1);
    check(nstarts == 1, "R3 code 0 boundary", nstarts, 1);
  endtask

  task automatic t_rewrite();
    write_rate(8'h03);
    nstarts = 0;
    ticks(10);
    write_rate(8'h04);
    ticks(7);
    check(nstarts == 0, "R5 restart before new period", nstarts, 0);
    ticks(1);
    check(nstarts == 1, "R5 one new period after write", nstarts, 1);
  endtask

  task automatic t_standby();
    write_rate(8'h06);
    ticks(1);
    standby_i = 1'b1;
    nstarts = 0;
    ticks(10);
    check(nstarts == 0, "R6 no starts in standby", nstarts, 0);
    standby_i = 1'b0;
    ticks(1);
    check(nstarts == 0, "R6 count cleared in standby", nstarts, 0);
    ticks(1);
    check(nstarts == 1, "R6 full period after run", nstarts, 1);
  endtask

  task automatic t_oneshot();
    standby_i = 1'b1;
    idle(8);
    nstarts = 0;
    pulse_oneshot();
    idle(10);
    check(nstarts == 1, "R7 exactly one cycle", nstarts, 1);
    check(busy_o == 1'b0, "R7 back to standby idle", int'(busy_o), 0);
    pulse_oneshot();
    idle(10);
    check(nstarts == 2, "R7 second strobe", nstarts, 2);
  endtask

  task automatic t_oneshot_ignored();
    standby_i = 1'b0;
    write_rate(8'h00);
    nstarts = 0;
    pulse_oneshot();
    idle(10);
    check(nstarts == 0, "R8 strobe in run", nstarts, 0);
    standby_i = 1'b1;
    lat = 20;
    idle(2);
    pulse_oneshot();
    idle(3);
    pulse_oneshot();
    idle(30);
    check(nstarts == 1, "R8 strobe while busy", nstarts, 1);
    lat = 2;
  endtask

  task automatic t_busy_boundary();
    standby_i = 1'b0;
    write_rate(8'h07);
    lat = 20;
    nstarts = 0;
    pulse_tick(2);
    check(busy_o == 1'b1, "R9 busy during cycle", int'(busy_o), 1);
    pulse_tick(1);
    check(nstarts == 1, "R9 boundary while busy", nstarts, 1);
    idle(25);
    check(busy_o == 1'b0, "R9 busy cleared", int'(busy_o), 0);
    lat = 2;
  endtask

  task automatic t_stray_done();
    standby_i = 1'b1;
    idle(4);
    man_done = 1'b1;
    @(negedge clk);
    man_done = 1'b0;
    check(busy_o == 1'b0, "R10 idle done ignored", int'(busy_o), 0);
    nstarts = 0;
    pulse_oneshot();
    idle(8);
    check(nstarts == 1, "R10 strobe still works", nstarts, 1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    idle(4);
    rst_ni = 1'b1;
    idle(1);
    t_reset();
    t_readback();
    t_pulse_shape();
    t_rates();
    t_rewrite();
    t_standby();
    t_oneshot();
    t_oneshot_ignored();
    t_busy_boundary();
    t_stray_done();
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule